// File: doc/BRIEF.md
# Machine/User Trap Entry Unit

This block handles trap entry for a small hart that runs in two privilege levels, user (encoding 0) and machine (encoding 3). A trap request arrives as one packed 32-bit word. Bit 31 marks it active, bits 30:16 carry the cause and bits 15:0 carry a trap identifier. On a taken trap the unit works out the final cause, records it with the faulting PC in the machine cause and exception-PC registers, and then presents a one-cycle redirect to the handler address held in the machine trap-vector register. An environment call (identifier 0, cause 11) is renumbered from the current privilege, so it reports 8 from user mode and 11 from machine mode.

Faults found during a fetch are not raised at once. A failed protection check, or a fetch address that is not aligned, posts a single pending request. The fetch stage then asks for a trap with the sentinel word 0xFFFFFFFF, which means "take whatever is pending". The pending request is used as the trap, and execution continues from the handler.

The unit also holds the trap CSRs of both levels. Trap-vector reads hide bit 1. Exception-PC writes are trimmed to instruction alignment. An interrupt-controller base CSR at address 0x7C0 is read-only. CSR addresses: user vector 0x005, user exception PC 0x041, user cause 0x042, machine vector 0x305, machine exception PC 0x341, machine cause 0x342.

Top module: `trap_entry_unit`

## Requirements
- R1: A take request whose word has bit 31 clear (and is not 0xFFFFFFFF) is ignored: no redirect, and the machine cause keeps its value.
- R2: When the identifier (bits 15:0) is 0 and the cause (bits 30:16) is 11, the recorded cause is 8 plus the privilege encoding: 8 from user (0), 11 from machine (3). Any other word records bits 30:16 unchanged.
- R3: On a taken trap, the machine cause (0x342) gets the zero-extended final cause and the machine exception PC (0x341) gets the PC with its alignment bits cleared. In the next cycle, redirect_valid_o is high for exactly one cycle with redirect_pc_o equal to the machine vector value with bits 1:0 cleared.
- R4: post_access_i posts a pending request with cause 1 and identifier 0.
- R5: A fetch check on an address whose alignment bits are non-zero posts a pending request with cause 0. With the default compressed support, only bit 0 counts; an aligned address posts nothing.
- R6: Only one request is pending. A post while one is pending is dropped. Taking the word 0xFFFFFFFF uses the pending request and clears it. That word with nothing pending takes no trap. A direct (non-sentinel) take leaves the pending request in place.
- R7: Reading either trap-vector CSR (0x005, 0x305) returns the stored value with bit 1 forced to 0.
- R8: Writing either exception-PC CSR (0x041, 0x341) stores the value with bit 0 cleared (bits 1:0 without compressed support).
- R9: The interrupt-controller base CSR (0x7C0) reads 0xC0000000 from reset and ignores writes.
- R10: After reset, redirect_valid_o is 0 and all trap CSRs read 0.
- R11: A trap update of the machine cause and exception PC wins over a CSR write to the same register in the same cycle.
- R12: csr_rdata_o is registered. It shows the register addressed in the previous cycle, and 0 for an unimplemented address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege encoding (0 user, 3 machine) |
| post_access_i | input | 1 | Protection check failed; post access-fault request |
| fetch_chk_i | input | 1 | Fetch address valid for alignment check |
| fetch_addr_i | input | XLEN | Fetch address |
| take_i | input | 1 | Take a trap this cycle |
| take_word_i | input | 32 | Packed trap request, or 0xFFFFFFFF to use the pending one |
| take_pc_i | input | XLEN | Faulting PC |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Registered CSR read data |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | XLEN | Handler address |

## Verification
On every cycle, the assertions check that the redirect address and the exception PC stay aligned, and that a trap-vector read never shows bit 1. They also check that the pending request holds until it is consumed and is cleared when it is used, that a user environment call records cause 8, and that an inactive word never produces a redirect. Other behaviour shows only in the bench's scenarios. This covers cause values for a spread of words and privileges, the read-only base CSR, and the ordering of posts against consumption. It also covers a CSR write that collides with a trap, and the exact cycle in which redirect and read data appear.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CAUSE_W = 15;
  localparam int unsigned ID_W    = 16;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned LEVELS  = 2;

  typedef struct packed {
    logic               active;
    logic [CAUSE_W-1:0] cause;
    logic [ID_W-1:0]    id;
  } trap_word_t;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] CAUSE_ENVCALL  = CAUSE_W'(11);
  localparam logic [CAUSE_W-1:0] CAUSE_ENV_BASE = CAUSE_W'(8);

  localparam logic [WORD_W-1:0] USE_PENDING = '1;

  // user-level addresses; machine level sits at +LEVEL_STEP
  localparam logic [CSR_AW-1:0] ADDR_TVEC  = 12'h005;
  localparam logic [CSR_AW-1:0] ADDR_EPC   = 12'h041;
  localparam logic [CSR_AW-1:0] ADDR_CAUSE = 12'h042;
  localparam logic [CSR_AW-1:0] LEVEL_STEP = 12'h300;
endpackage

// File: rtl/trap_pending.sv
module trap_pending
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       post_access_i,
  input  logic       post_misalign_i,
  input  logic       consume_i,
  output trap_word_t pend_o
);
  trap_word_t pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (consume_i) pend_d = '0;
    if (!pend_d.active) begin
      if (post_access_i)
        pend_d = '{active: 1'b1, cause: CAUSE_ACCESS, id: '0};
      else if (post_misalign_i)
        pend_d = '{active: 1'b1, cause: CAUSE_MISALIGN, id: '0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: a held request is not overwritten by later posts
  a_r6_pending_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q.active && !consume_i) |=> $stable(pend_q));

  // R6: consuming without a new post leaves nothing pending
  a_r6_pending_clear: assert property (@(posedge clk) disable iff (rst)
    (consume_i && !post_access_i && !post_misalign_i) |=> !pend_q.active);
endmodule

// File: rtl/trap_cause.sv
module trap_cause
  import trap_pkg::*;
(
  input  trap_word_t          word_i,
  input  logic [1:0]          priv_i,
  output logic [CAUSE_W-1:0]  cause_o
);
  always_comb begin
    if (word_i.id == '0 && word_i.cause == CAUSE_ENVCALL)
      cause_o = CAUSE_ENV_BASE + CAUSE_W'(priv_i);
    else
      cause_o = word_i.cause;
  end
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_pkg::*;
#(
  parameter int unsigned         XLEN      = 32,
  parameter bit                  C_EXT     = 1'b1,
  parameter logic [XLEN-1:0]     BASE_RST  = 32'hC000_0000,
  parameter logic [CSR_AW-1:0]   BASE_ADDR = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  input  logic              trap_we_i,
  input  logic [XLEN-1:0]   trap_cause_i,
  input  logic [XLEN-1:0]   trap_epc_i,
  output logic [XLEN-1:0]   mtvec_o,
  output logic [XLEN-1:0]   mcause_o
);
  localparam logic [XLEN-1:0] LOW_BITS = C_EXT ? XLEN'(1) : XLEN'(3);
  localparam logic [XLEN-1:0] PC_MASK  = ~LOW_BITS;
  localparam logic [XLEN-1:0] TVEC_RD  = ~XLEN'(2);
  localparam int unsigned     M_LVL    = LEVELS - 1;

  logic [XLEN-1:0] tvec_w  [LEVELS];
  logic [XLEN-1:0] epc_w   [LEVELS];
  logic [XLEN-1:0] cause_w [LEVELS];
  logic [XLEN-1:0] rd_d;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam logic [CSR_AW-1:0] OFS = CSR_AW'(lv * LEVEL_STEP);
    localparam bit TRAP_LVL = (lv == M_LVL);
    logic [XLEN-1:0] tvec_q, epc_q, cause_q;
    logic hit_tvec, hit_epc, hit_cause, trap_here;

    assign hit_tvec  = csr_we_i && (csr_addr_i == ADDR_TVEC  + OFS);
    assign hit_epc   = csr_we_i && (csr_addr_i == ADDR_EPC   + OFS);
    assign hit_cause = csr_we_i && (csr_addr_i == ADDR_CAUSE + OFS);
    assign trap_here = TRAP_LVL && trap_we_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        tvec_q  <= '0;
        epc_q   <= '0;
        cause_q <= '0;
      end else begin
        if (hit_tvec) tvec_q <= csr_wdata_i;
        if (trap_here) begin
          epc_q   <= trap_epc_i;
          cause_q <= trap_cause_i;
        end else begin
          if (hit_epc)   epc_q   <= csr_wdata_i & PC_MASK;
          if (hit_cause) cause_q <= csr_wdata_i;
        end
      end
    end

    assign tvec_w[lv]  = tvec_q;
    assign epc_w[lv]   = epc_q;
    assign cause_w[lv] = cause_q;

    // R8: stored exception PC never carries alignment bits
    a_r8_epc_aligned: assert property (@(posedge clk) disable iff (rst)
      (epc_q & LOW_BITS) == '0);
  end

  always_comb begin
    rd_d = '0;
    for (int lv = 0; lv < int'(LEVELS); lv++) begin
      if (csr_addr_i == ADDR_TVEC  + CSR_AW'(lv * LEVEL_STEP)) rd_d = tvec_w[lv] & TVEC_RD;
      if (csr_addr_i == ADDR_EPC   + CSR_AW'(lv * LEVEL_STEP)) rd_d = epc_w[lv];
      if (csr_addr_i == ADDR_CAUSE + CSR_AW'(lv * LEVEL_STEP)) rd_d = cause_w[lv];
    end
    if (csr_addr_i == BASE_ADDR) rd_d = BASE_RST;
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata_o <= '0;
    else     csr_rdata_o <= rd_d;
  end

  assign mtvec_o  = tvec_w[M_LVL];
  assign mcause_o = cause_w[M_LVL];

  // R7: a vector read never shows bit 1
  a_r7_tvec_bit1: assert property (@(posedge clk) disable iff (rst)
    ($past(csr_addr_i) == ADDR_TVEC || $past(csr_addr_i) == ADDR_TVEC + LEVEL_STEP)
      |-> csr_rdata_o[1] == 1'b0);

  // R11: trap data lands in the machine exception PC despite a CSR write
  a_r11_trap_wins: assert property (@(posedge clk) disable iff (rst)
    trap_we_i |=> epc_w[M_LVL] == $past(trap_epc_i));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned       XLEN      = 32,
  parameter bit                C_EXT     = 1'b1,
  parameter logic [XLEN-1:0]   BASE_RST  = 32'hC000_0000,
  parameter logic [CSR_AW-1:0] BASE_ADDR = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        priv_i,
  input  logic              post_access_i,
  input  logic              fetch_chk_i,
  input  logic [XLEN-1:0]   fetch_addr_i,
  input  logic              take_i,
  input  logic [WORD_W-1:0] take_word_i,
  input  logic [XLEN-1:0]   take_pc_i,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o
);
  localparam logic [XLEN-1:0] LOW_BITS = C_EXT ? XLEN'(1) : XLEN'(3);
  localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

  trap_word_t         pend, req_word;
  logic               use_pend, fire, consume, misalign;
  logic [CAUSE_W-1:0] final_cause;
  logic [XLEN-1:0]    mtvec, mcause;

  assign misalign = fetch_chk_i && ((fetch_addr_i & LOW_BITS) != '0);
  assign use_pend = take_i && (take_word_i == USE_PENDING);
  assign req_word = use_pend ? pend : trap_word_t'(take_word_i);
  assign fire     = take_i && req_word.active;
  assign consume  = use_pend && pend.active;

  trap_pending u_pending (
    .clk             (clk),
    .rst             (rst),
    .post_access_i   (post_access_i),
    .post_misalign_i (misalign),
    .consume_i       (consume),
    .pend_o          (pend)
  );

  trap_cause u_cause (
    .word_i  (req_word),
    .priv_i  (priv_i),
    .cause_o (final_cause)
  );

  trap_csr_file #(
    .XLEN      (XLEN),
    .C_EXT     (C_EXT),
    .BASE_RST  (BASE_RST),
    .BASE_ADDR (BASE_ADDR)
  ) u_csr (
    .clk          (clk),
    .rst          (rst),
    .csr_we_i     (csr_we_i),
    .csr_addr_i   (csr_addr_i),
    .csr_wdata_i  (csr_wdata_i),
    .csr_rdata_o  (csr_rdata_o),
    .trap_we_i    (fire),
    .trap_cause_i (XLEN'(final_cause)),
    .trap_epc_i   (take_pc_i & ~LOW_BITS),
    .mtvec_o      (mtvec),
    .mcause_o     (mcause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      redirect_valid_o <= fire;
      if (fire) redirect_pc_o <= mtvec & VEC_MASK;
    end
  end

  // R3: handler address is word aligned
  a_r3_redirect_aligned: assert property (@(posedge clk) disable iff (rst)
    redirect_valid_o |-> redirect_pc_o[1:0] == 2'b00);

  // R1: an inactive direct word never redirects
  a_r1_inactive_ignored: assert property (@(posedge clk) disable iff (rst)
    (take_i && !take_word_i[WORD_W-1]) |=> !redirect_valid_o);

  // R2: environment call from user mode records cause 8
  a_r2_envcall_user: assert property (@(posedge clk) disable iff (rst)
    (fire && req_word.id == '0 && req_word.cause == CAUSE_ENVCALL && priv_i == PRIV_U)
      |=> mcause == XLEN'(8));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
  localparam int XLEN = 32;
  localparam int NVEC = 6;
  localparam logic [11:0] A_MTVEC = 12'h305, A_MEPC = 12'h341, A_MCAUSE = 12'h342;
  localparam logic [11:0] A_UTVEC = 12'h005, A_UEPC = 12'h041, A_UCAUSE = 12'h042;
  localparam logic [11:0] A_BASE  = 12'h7C0;
  localparam logic [31:0] SENT    = 32'hFFFF_FFFF;
  localparam logic [31:0] HANDLER = 32'h8000_0104;

  // {priv, word, pc, expected cause, expected epc}
  localparam logic [129:0] VEC [NVEC] = '{
    {2'd3, 32'h800B_0000, 32'h0000_0100, 32'd11,     32'h0000_0100},
    {2'd0, 32'h800B_0000, 32'h0000_0204, 32'd8,      32'h0000_0204},
    {2'd0, 32'h800B_0005, 32'h0000_0301, 32'd11,     32'h0000_0300},
    {2'd3, 32'h8002_0000, 32'h0000_0403, 32'd2,      32'h0000_0402},
    {2'd0, 32'h8003_0007, 32'h0000_5000, 32'd3,      32'h0000_5000},
    {2'd3, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h7FFF,   32'hFFFF_FFFE}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] priv = 2'd3;
  logic post_access = 0, fetch_chk = 0, take = 0, csr_we = 0;
  logic [31:0] fetch_addr = '0, take_word = '0, take_pc = '0, csr_wdata = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_rdata, redirect_pc;
  logic redirect_valid;
  int checks = 0, errors = 0;
  bit done = 0;
  logic rv;
  logic [31:0] rpc, rd;

  always #5 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rst(rst), .priv_i(priv), .post_access_i(post_access),
    .fetch_chk_i(fetch_chk), .fetch_addr_i(fetch_addr), .take_i(take),
    .take_word_i(take_word), .take_pc_i(take_pc), .csr_we_i(csr_we),
    .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_read(logic [11:0] a, output logic [31:0] d);
    csr_addr = a; tick(); d = csr_rdata;
  endtask

  task automatic csr_write(logic [11:0] a, logic [31:0] v);
    csr_we = 1; csr_addr = a; csr_wdata = v; tick(); csr_we = 0;
  endtask

  task automatic do_take(logic [1:0] p, logic [31:0] w, logic [31:0] pc);
    priv = p; take = 1; take_word = w; take_pc = pc; tick();
    take = 0; rv = redirect_valid; rpc = redirect_pc;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10: reset state
    check("R10 redirect after reset", {31'd0, redirect_valid}, 32'd0);
    csr_read(A_MTVEC, rd);  check("R10 mtvec reset", rd, 32'd0);
    csr_read(A_MEPC, rd);   check("R10 mepc reset", rd, 32'd0);
    csr_read(A_UCAUSE, rd); check("R10 ucause reset", rd, 32'd0);
    // R9: base CSR
    csr_read(A_BASE, rd);   check("R9 base reset", rd, 32'hC000_0000);
    csr_write(A_BASE, 32'h1234_5678);
    csr_read(A_BASE, rd);   check("R9 base write ignored", rd, 32'hC000_0000);
    // R7: vector read hides bit 1
    csr_write(A_MTVEC, 32'h8000_0107);
    csr_read(A_MTVEC, rd);  check("R7 mtvec read", rd, 32'h8000_0105);
    csr_write(A_UTVEC, 32'h0000_00FF);
    csr_read(A_UTVEC, rd);  check("R7 utvec read", rd, 32'h0000_00FD);
    // R8: exception PC write masking
    csr_write(A_UEPC, 32'h0000_0333);
    csr_read(A_UEPC, rd);   check("R8 uepc masked", rd, 32'h0000_0332);
    csr_write(A_MEPC, 32'h0000_0007);
    csr_read(A_MEPC, rd);   check("R8 mepc masked", rd, 32'h0000_0006);
    // R12: plain cause storage and unknown address
    csr_write(A_UCAUSE, 32'h5);
    csr_read(A_UCAUSE, rd); check("R12 ucause read", rd, 32'h5);
    csr_read(12'h123, rd);  check("R12 unknown address", rd, 32'd0);

    // R2/R3: vector table
    for (int i = 0; i < NVEC; i++) begin
      do_take(VEC[i][129:128], VEC[i][127:96], VEC[i][95:64]);
      check("R3 redirect valid", {31'd0, rv}, 32'd1);
      check("R3 redirect pc", rpc, HANDLER);
      csr_read(A_MCAUSE, rd); check("R2 final cause", rd, VEC[i][63:32]);
      check("R3 redirect one cycle", {31'd0, redirect_valid}, 32'd0);
      csr_read(A_MEPC, rd);   check("R3 epc", rd, VEC[i][31:0]);
    end

    // R1: inactive word
    do_take(2'd3, 32'h000B_0000, 32'h0000_0800);
    check("R1 inactive no redirect", {31'd0, rv}, 32'd0);
    csr_read(A_MCAUSE, rd); check("R1 cause kept", rd, 32'h7FFF);

    // R4: access fault posted then taken
    post_access = 1; tick(); post_access = 0;
    do_take(2'd3, SENT, 32'h0000_0600);
    check("R4 pending redirect", {31'd0, rv}, 32'd1);
    csr_read(A_MCAUSE, rd); check("R4 access cause", rd, 32'd1);
    csr_read(A_MEPC, rd);   check("R4 epc", rd, 32'h0000_0600);
    // R6: nothing pending after consumption
    do_take(2'd3, SENT, 32'h0000_0604);
    check("R6 empty sentinel no redirect", {31'd0, rv}, 32'd0);

    // R5/R6: misaligned fetch posted, later access fault dropped
    fetch_chk = 1; fetch_addr = 32'h0000_1001; tick(); fetch_chk = 0;
    post_access = 1; tick(); post_access = 0;
    do_take(2'd0, SENT, 32'h0000_1001);
    check("R5 misalign redirect", {31'd0, rv}, 32'd1);
    csr_read(A_MCAUSE, rd); check("R6 first post kept (R5 cause 0)", rd, 32'd0);
    csr_read(A_MEPC, rd);   check("R5 epc", rd, 32'h0000_1000);

    // R5: aligned fetch posts nothing
    fetch_chk = 1; fetch_addr = 32'h0000_1002; tick(); fetch_chk = 0;
    do_take(2'd3, SENT, 32'h0000_1002);
    check("R5 aligned no trap", {31'd0, rv}, 32'd0);

    // R6: direct take leaves pending request
    post_access = 1; tick(); post_access = 0;
    do_take(2'd3, 32'h8003_0000, 32'h0000_0900);
    csr_read(A_MCAUSE, rd); check("R6 direct cause", rd, 32'd3);
    do_take(2'd3, SENT, 32'h0000_0904);
    check("R6 pending survived", {31'd0, rv}, 32'd1);
    csr_read(A_MCAUSE, rd); check("R6 pending cause", rd, 32'd1);

    // R11: trap beats same-cycle CSR write
    csr_we = 1; csr_addr = A_MEPC; csr_wdata = 32'h0000_0998;
    do_take(2'd3, 32'h8002_0000, 32'h0000_0700);
    csr_we = 0;
    csr_read(A_MEPC, rd); check("R11 epc from trap", rd, 32'h0000_0700);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule